// File: doc/BRIEF.md
# Search-Area Input Buffer with Rotating Cluster Sets

The block sits between a frame store and a block-matching processing array. It takes search-area pixels from a plain write stream and holds them so that the array can be fed from two pairs of output lines. The two main lines read the top N rows of the search area from an upper cluster. The two force lines read the remaining KMAX rows from a lower cluster. Every cluster is split into an even-row bank and an odd-row bank, so one read returns two vertically adjacent pixels of one column in the same slot. A second pair of write ports, the update buses, copies a row pair from the current lower cluster into the upper cluster being prepared. This lets rows already fetched for one block be reused as the top rows of another.

The block keeps two upper clusters (current and next) and three lower clusters (previous, current and next). A one-cycle block-boundary pulse rotates their roles. The upper pair swaps. The lower trio moves forward by one, and the old previous set becomes the new next set. Source writes always go to the next set, and reads always come from the current or previous set, so loading overlaps computation. The template block is held in a ping-pong pair of banks that swap on the same pulse.

Top module: `sab_input_buffer`

## Requirements
- R1: While reset is asserted, and after it is released, main_e, main_o, force_e, force_o, force_vld and tpl_pix read zero until the first read request.
- R2: A pixel written with wr_lower=0 to a row pair and column appears on the main lines after one blk_swap pulse. A main read of pair p and column c returns row 2p on main_e and row 2p+1 on main_o, one cycle after main_en.
- R3: A pixel written with wr_lower=1 appears on the force lines with force_prev=0 after one blk_swap pulse, and with force_prev=1 after two pulses.
- R4: In one cycle, the even-row write (wr_we_e, wr_pix_e) and the odd-row write (wr_we_o, wr_pix_o) land in rows 2p and 2p+1 independently. Either row can be written alone.
- R5: force_vld goes high one cycle after an accepted force_en. When force_vld is low, force_e and force_o are zero.
- R6: With upd_en high, rows 2s and 2s+1 at column upd_col of the current lower set are copied in one cycle into rows 2d and 2d+1 of the next upper set, where s is upd_src_pair and d is upd_dst_pair.
- R7: While upd_en is high, a source write aimed at the upper set (wr_lower=0) is ignored. A source write aimed at the lower set still takes effect.
- R8: tpl_pix returns, one cycle after tpl_re, the word written by tpl_we before the most recent blk_swap. Writes made after that pulse stay hidden until the next pulse.
- R9: With main_en low, main_e and main_o hold their value. With tpl_re low, tpl_pix holds its value.
- R10: Writes to the next set never change what the current main or force reads return before the next blk_swap.
- R11: A force read of the current lower set (force_prev=0) in a cycle with upd_en high is dropped. The next cycle shows force_vld=0 and zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_swap | input | 1 | Block-boundary pulse; rotates set roles |
| wr_we_e | input | 1 | Source write enable, even row |
| wr_we_o | input | 1 | Source write enable, odd row |
| wr_lower | input | 1 | 1 selects the next lower set, 0 the next upper set |
| wr_pair | input | 2 | Row-pair index of the source write |
| wr_col | input | 4 | Column of the source write |
| wr_pix_e | input | 8 | Even-row source pixel |
| wr_pix_o | input | 8 | Odd-row source pixel |
| upd_en | input | 1 | Update-bus copy enable |
| upd_src_pair | input | 2 | Row pair read from the current lower set |
| upd_dst_pair | input | 2 | Row pair written in the next upper set |
| upd_col | input | 4 | Column of the copy |
| main_en | input | 1 | Main-line read request |
| main_pair | input | 2 | Row pair of the main read |
| main_col | input | 4 | Column of the main read |
| main_e | output | 8 | Main line, even row |
| main_o | output | 8 | Main line, odd row |
| force_en | input | 1 | Force-line read request |
| force_prev | input | 1 | 1 reads the previous lower set, 0 the current one |
| force_pair | input | 2 | Row pair of the force read |
| force_col | input | 4 | Column of the force read |
| force_e | output | 8 | Force line, even row |
| force_o | output | 8 | Force line, odd row |
| force_vld | output | 1 | Force lines carry data |
| tpl_we | input | 1 | Template write enable |
| tpl_waddr | input | 4 | Template write address |
| tpl_wpix | input | 8 | Template write pixel |
| tpl_re | input | 1 | Template read request |
| tpl_raddr | input | 4 | Template read address |
| tpl_pix | output | 8 | Template read pixel |

## Verification
All read results pass through one output register. The data for a request driven before clock edge t is therefore due after edge t. The bench applies its inputs away from the edge, advances one edge, and compares at the following falling edge. Writes and role rotation also take effect at edge t, but every read in that same cycle still sees the state before the edge. The bench model therefore computes each expected output from its stored contents first, and only then applies the cycle's writes, copy and rotation. Held outputs are checked against the last expected value carried forward whenever no request is made.

// File: rtl/sab_pkg.sv
package sab_pkg;
  localparam int UP_COPIES = 2;
  localparam int LO_COPIES = 3;

  function automatic logic [1:0] mod3_inc(input logic [1:0] v);
    return (v == 2'd2) ? 2'd0 : v + 2'd1;
  endfunction
endpackage

// File: rtl/sab_bank.sv
module sab_bank #(
  parameter int PW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [PW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [PW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sab_cluster.sv
module sab_cluster #(
  parameter int PW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we_e,
  input  logic          we_o,
  input  logic [AW-1:0] waddr,
  input  logic [PW-1:0] wdata_e,
  input  logic [PW-1:0] wdata_o,
  input  logic [AW-1:0] raddr,
  output logic [PW-1:0] rdata_e,
  output logic [PW-1:0] rdata_o
);
  sab_bank #(.PW(PW), .AW(AW)) u_even (
    .clk(clk), .we(we_e), .waddr(waddr), .wdata(wdata_e),
    .raddr(raddr), .rdata(rdata_e)
  );
  sab_bank #(.PW(PW), .AW(AW)) u_odd (
    .clk(clk), .we(we_o), .waddr(waddr), .wdata(wdata_o),
    .raddr(raddr), .rdata(rdata_o)
  );
endmodule

// File: rtl/sab_roles.sv
module sab_roles
  import sab_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       swap,
  output logic       phase,
  output logic [1:0] lo_cur,
  output logic [1:0] lo_next,
  output logic [1:0] lo_prev
);
  logic       phase_d;
  logic [1:0] lo_cur_d;

  always_comb begin
    phase_d  = swap ? ~phase : phase;
    lo_cur_d = swap ? mod3_inc(lo_cur) : lo_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= 1'b0;
      lo_cur <= 2'd0;
    end else begin
      phase  <= phase_d;
      lo_cur <= lo_cur_d;
    end
  end

  assign lo_next = mod3_inc(lo_cur);
  assign lo_prev = mod3_inc(lo_next);
endmodule

// File: rtl/sab_input_buffer.sv
module sab_input_buffer
  import sab_pkg::*;
#(
  parameter int PW   = 8,
  parameter int N    = 4,
  parameter int KMAX = 8,
  localparam int COLS     = N + KMAX,
  localparam int UP_PAIRS = N / 2,
  localparam int LO_PAIRS = KMAX / 2,
  localparam int MAXP     = (LO_PAIRS > UP_PAIRS) ? LO_PAIRS : UP_PAIRS,
  localparam int PRW      = (MAXP > 1) ? $clog2(MAXP) : 1,
  localparam int CW       = $clog2(COLS),
  localparam int TAW      = $clog2(N * N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           blk_swap,
  input  logic           wr_we_e,
  input  logic           wr_we_o,
  input  logic           wr_lower,
  input  logic [PRW-1:0] wr_pair,
  input  logic [CW-1:0]  wr_col,
  input  logic [PW-1:0]  wr_pix_e,
  input  logic [PW-1:0]  wr_pix_o,
  input  logic           upd_en,
  input  logic [PRW-1:0] upd_src_pair,
  input  logic [PRW-1:0] upd_dst_pair,
  input  logic [CW-1:0]  upd_col,
  input  logic           main_en,
  input  logic [PRW-1:0] main_pair,
  input  logic [CW-1:0]  main_col,
  output logic [PW-1:0]  main_e,
  output logic [PW-1:0]  main_o,
  input  logic           force_en,
  input  logic           force_prev,
  input  logic [PRW-1:0] force_pair,
  input  logic [CW-1:0]  force_col,
  output logic [PW-1:0]  force_e,
  output logic [PW-1:0]  force_o,
  output logic           force_vld,
  input  logic           tpl_we,
  input  logic [TAW-1:0] tpl_waddr,
  input  logic [PW-1:0]  tpl_wpix,
  input  logic           tpl_re,
  input  logic [TAW-1:0] tpl_raddr,
  output logic [PW-1:0]  tpl_pix
);
  localparam int AW = $clog2(MAXP * COLS);

  function automatic logic [AW-1:0] addr_of(input logic [PRW-1:0] p, input logic [CW-1:0] c);
    return AW'(p) * AW'(COLS) + AW'(c);
  endfunction

  logic       phase;
  logic [1:0] lo_cur, lo_next, lo_prev;

  sab_roles u_roles (
    .clk(clk), .rst_n(rst_n), .swap(blk_swap), .phase(phase),
    .lo_cur(lo_cur), .lo_next(lo_next), .lo_prev(lo_prev)
  );

  logic [AW-1:0] wr_addr, upd_src_addr, upd_dst_addr, main_addr, force_addr;
  assign wr_addr      = addr_of(wr_pair, wr_col);
  assign upd_src_addr = addr_of(upd_src_pair, upd_col);
  assign upd_dst_addr = addr_of(upd_dst_pair, upd_col);
  assign main_addr    = addr_of(main_pair, main_col);
  assign force_addr   = addr_of(force_pair, force_col);

  logic [PW-1:0] up_rd_e [UP_COPIES];
  logic [PW-1:0] up_rd_o [UP_COPIES];
  logic [PW-1:0] lo_rd_e [LO_COPIES];
  logic [PW-1:0] lo_rd_o [LO_COPIES];
  logic [PW-1:0] tpl_rd  [2];
  logic [PW-1:0] upd_bus_e, upd_bus_o;

  // update buses carry the current lower set's read port
  assign upd_bus_e = lo_rd_e[lo_cur];
  assign upd_bus_o = lo_rd_o[lo_cur];

  for (genvar g = 0; g < UP_COPIES; g++) begin : g_up
    logic sel_next;
    assign sel_next = (phase != 1'(g));
    sab_cluster #(.PW(PW), .AW(AW)) u_cl (
      .clk(clk),
      .we_e(sel_next & (upd_en | (wr_we_e & ~wr_lower))),
      .we_o(sel_next & (upd_en | (wr_we_o & ~wr_lower))),
      .waddr(upd_en ? upd_dst_addr : wr_addr),
      .wdata_e(upd_en ? upd_bus_e : wr_pix_e),
      .wdata_o(upd_en ? upd_bus_o : wr_pix_o),
      .raddr(main_addr),
      .rdata_e(up_rd_e[g]),
      .rdata_o(up_rd_o[g])
    );
  end

  for (genvar g = 0; g < LO_COPIES; g++) begin : g_lo
    logic is_next, is_cur;
    assign is_next = (lo_next == 2'(g));
    assign is_cur  = (lo_cur == 2'(g));
    sab_cluster #(.PW(PW), .AW(AW)) u_cl (
      .clk(clk),
      .we_e(is_next & wr_lower & wr_we_e),
      .we_o(is_next & wr_lower & wr_we_o),
      .waddr(wr_addr),
      .wdata_e(wr_pix_e),
      .wdata_o(wr_pix_o),
      .raddr((is_cur & upd_en) ? upd_src_addr : force_addr),
      .rdata_e(lo_rd_e[g]),
      .rdata_o(lo_rd_o[g])
    );
  end

  for (genvar g = 0; g < 2; g++) begin : g_tpl
    sab_bank #(.PW(PW), .AW(TAW)) u_bank (
      .clk(clk),
      .we(tpl_we & (phase == 1'(g))),
      .waddr(tpl_waddr),
      .wdata(tpl_wpix),
      .raddr(tpl_raddr),
      .rdata(tpl_rd[g])
    );
  end

  // output stage: next-state
  logic          force_hit;
  logic [1:0]    force_idx;
  logic [PW-1:0] main_e_d, main_o_d, force_e_d, force_o_d, tpl_pix_d;

  always_comb begin
    force_hit = force_en & ~(upd_en & ~force_prev);
    force_idx = force_prev ? lo_prev : lo_cur;
    main_e_d  = main_en ? up_rd_e[phase] : main_e;
    main_o_d  = main_en ? up_rd_o[phase] : main_o;
    force_e_d = force_hit ? lo_rd_e[force_idx] : '0;
    force_o_d = force_hit ? lo_rd_o[force_idx] : '0;
    tpl_pix_d = tpl_re ? tpl_rd[~phase] : tpl_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_e    <= '0;
      main_o    <= '0;
      force_e   <= '0;
      force_o   <= '0;
      force_vld <= 1'b0;
      tpl_pix   <= '0;
    end else begin
      main_e    <= main_e_d;
      main_o    <= main_o_d;
      force_e   <= force_e_d;
      force_o   <= force_o_d;
      force_vld <= force_hit;
      tpl_pix   <= tpl_pix_d;
    end
  end
endmodule

// File: rtl/sab_input_buffer_chk.sv
module sab_input_buffer_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blk_swap,
  input logic          upd_en,
  input logic          main_en,
  input logic [PW-1:0] main_e,
  input logic [PW-1:0] main_o,
  input logic          force_en,
  input logic          force_prev,
  input logic [PW-1:0] force_e,
  input logic [PW-1:0] force_o,
  input logic          force_vld,
  input logic          tpl_re,
  input logic [PW-1:0] tpl_pix,
  input logic          phase,
  input logic [1:0]    lo_cur
);
  a_r5_force_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en && !(upd_en && !force_prev)) |=> force_vld);

  a_r11_force_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en && upd_en && !force_prev) |=> !force_vld);

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !force_vld |-> (force_e == '0 && force_o == '0));

  a_r9_main_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !main_en |=> ($stable(main_e) && $stable(main_o)));

  a_r9_tpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tpl_re |=> $stable(tpl_pix));

  a_r2_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    blk_swap |=> (phase != $past(phase)));

  a_r10_phase_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_swap |=> ($stable(phase) && $stable(lo_cur)));

  a_r3_lower_moves: assert property (@(posedge clk) disable iff (!rst_n)
    blk_swap |=> (lo_cur != $past(lo_cur)));

  a_r3_lower_range: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cur != 2'd3);
endmodule

bind sab_input_buffer sab_input_buffer_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_swap(blk_swap), .upd_en(upd_en),
  .main_en(main_en), .main_e(main_e), .main_o(main_o),
  .force_en(force_en), .force_prev(force_prev), .force_e(force_e),
  .force_o(force_o), .force_vld(force_vld), .tpl_re(tpl_re),
  .tpl_pix(tpl_pix), .phase(phase), .lo_cur(lo_cur)
);

// File: tb/sim_sab_input_buffer.sv
`timescale 1ns/1ps
module sim_sab_input_buffer;
  localparam int COLS = 12;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic       blk_swap, wr_we_e, wr_we_o, wr_lower, upd_en;
  logic [1:0] wr_pair, upd_src_pair, upd_dst_pair, main_pair, force_pair;
  logic [3:0] wr_col, upd_col, main_col, force_col, tpl_waddr, tpl_raddr;
  logic [7:0] wr_pix_e, wr_pix_o, tpl_wpix;
  logic       main_en, force_en, force_prev, tpl_we, tpl_re;
  logic [7:0] main_e, main_o, force_e, force_o, tpl_pix;
  logic       force_vld;

  sab_input_buffer u0 (.*);

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // model arrays indexed by role: mu 0=cur 1=next; ml 0=prev 1=cur 2=next; mt 0=read 1=write
  logic [7:0] mu [2][4][COLS];
  logic [7:0] ml [3][8][COLS];
  logic [7:0] mt [2][16];
  logic [7:0] x_me = 0, x_mo = 0, x_fe = 0, x_fo = 0, x_tp = 0;
  logic       x_fv = 0;

  task automatic chk(string t, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic idle();
    blk_swap = 0; wr_we_e = 0; wr_we_o = 0; wr_lower = 0; wr_pair = 0; wr_col = 0;
    wr_pix_e = 0; wr_pix_o = 0; upd_en = 0; upd_src_pair = 0; upd_dst_pair = 0;
    upd_col = 0; main_en = 0; main_pair = 0; main_col = 0; force_en = 0;
    force_prev = 0; force_pair = 0; force_col = 0; tpl_we = 0; tpl_waddr = 0;
    tpl_wpix = 0; tpl_re = 0; tpl_raddr = 0;
  endtask

  task automatic step();
    logic hit;
    // expected outputs from state before the edge
    if (main_en) begin
      x_me = mu[0][2*main_pair][main_col];
      x_mo = mu[0][2*main_pair+1][main_col];
    end
    hit = force_en && !(upd_en && !force_prev);
    x_fv = hit;
    x_fe = hit ? ml[force_prev ? 0 : 1][2*force_pair][force_col] : 8'h00;
    x_fo = hit ? ml[force_prev ? 0 : 1][2*force_pair+1][force_col] : 8'h00;
    if (tpl_re) x_tp = mt[0][tpl_raddr];
    // state updates
    if (upd_en) begin
      mu[1][2*upd_dst_pair][upd_col]   = ml[1][2*upd_src_pair][upd_col];
      mu[1][2*upd_dst_pair+1][upd_col] = ml[1][2*upd_src_pair+1][upd_col];
    end else if (!wr_lower) begin
      if (wr_we_e) mu[1][2*wr_pair][wr_col] = wr_pix_e;
      if (wr_we_o) mu[1][2*wr_pair+1][wr_col] = wr_pix_o;
    end
    if (wr_lower) begin
      if (wr_we_e) ml[2][2*wr_pair][wr_col] = wr_pix_e;
      if (wr_we_o) ml[2][2*wr_pair+1][wr_col] = wr_pix_o;
    end
    if (tpl_we) mt[1][tpl_waddr] = tpl_wpix;
    if (blk_swap) begin
      for (int r = 0; r < 4; r++) for (int c = 0; c < COLS; c++) begin
        logic [7:0] t; t = mu[0][r][c]; mu[0][r][c] = mu[1][r][c]; mu[1][r][c] = t;
      end
      for (int r = 0; r < 8; r++) for (int c = 0; c < COLS; c++) begin
        logic [7:0] t; t = ml[0][r][c];
        ml[0][r][c] = ml[1][r][c]; ml[1][r][c] = ml[2][r][c]; ml[2][r][c] = t;
      end
      for (int a = 0; a < 16; a++) begin
        logic [7:0] t; t = mt[0][a]; mt[0][a] = mt[1][a]; mt[1][a] = t;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "main_e", main_e, x_me);
    chk(tag, "main_o", main_o, x_mo);
    chk(tag, "force_e", force_e, x_fe);
    chk(tag, "force_o", force_o, x_fo);
    chk(tag, "force_vld", {7'd0, force_vld}, {7'd0, x_fv});
    chk(tag, "tpl_pix", tpl_pix, x_tp);
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1", "main_e", main_e, 0); chk("R1", "main_o", main_o, 0);
    chk("R1", "force_e", force_e, 0); chk("R1", "force_vld", {7'd0, force_vld}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "tpl_pix", tpl_pix, 0); chk("R1", "force_o", force_o, 0);

    // fill every set through the rotation (R2, R3)
    tag = "R2";
    for (int rnd = 0; rnd < 3; rnd++) begin
      for (int i = 0; i < 4 * COLS; i++) begin
        wr_lower = 1; wr_we_e = 1; wr_we_o = 1;
        wr_pair = 2'(i / COLS); wr_col = 4'(i % COLS);
        wr_pix_e = 8'($urandom); wr_pix_o = 8'($urandom);
        if (i < 16) begin tpl_we = 1; tpl_waddr = 4'(i); tpl_wpix = 8'($urandom); end
        step();
        if (i < 2 * COLS) begin
          wr_lower = 0; wr_we_e = 1; wr_we_o = 1;
          wr_pair = 2'(i / COLS); wr_col = 4'(i % COLS);
          wr_pix_e = 8'($urandom); wr_pix_o = 8'($urandom);
          step();
        end
      end
      blk_swap = 1; step();
    end

    // R4: even row only, odd row only, then read both
    tag = "R4";
    wr_we_e = 1; wr_pair = 1; wr_col = 7; wr_pix_e = 8'hA5; step();
    wr_we_o = 1; wr_pair = 0; wr_col = 7; wr_pix_o = 8'h5A; step();
    blk_swap = 1; step();
    main_en = 1; main_pair = 1; main_col = 7; step();
    main_en = 1; main_pair = 0; main_col = 7; step();

    // R10: write next upper and lower at locations currently being read
    tag = "R10";
    wr_we_e = 1; wr_we_o = 1; wr_pair = 0; wr_col = 7; wr_pix_e = 8'h11; wr_pix_o = 8'h22;
    main_en = 1; main_pair = 0; main_col = 7; step();
    main_en = 1; main_pair = 0; main_col = 7; step();
    wr_lower = 1; wr_we_e = 1; wr_pair = 3; wr_col = 2; wr_pix_e = 8'h33;
    force_en = 1; force_pair = 3; force_col = 2; step();
    force_en = 1; force_pair = 3; force_col = 2; step();

    // R3: lower pixel moves next -> cur -> prev
    tag = "R3";
    wr_lower = 1; wr_we_e = 1; wr_we_o = 1; wr_pair = 2; wr_col = 11;
    wr_pix_e = 8'hC3; wr_pix_o = 8'h3C; step();
    blk_swap = 1; step();
    force_en = 1; force_pair = 2; force_col = 11; step();
    blk_swap = 1; step();
    force_en = 1; force_prev = 1; force_pair = 2; force_col = 11; step();

    // R5: valid flag tracks request, idle slots carry zero
    tag = "R5";
    force_en = 1; force_prev = 1; force_pair = 1; force_col = 0; step();
    step();
    force_en = 1; force_pair = 0; force_col = 5; step();

    // R6: copy cur lower pair into next upper pair, then expose on main
    tag = "R6";
    upd_en = 1; upd_src_pair = 3; upd_dst_pair = 1; upd_col = 4; step();
    blk_swap = 1; step();
    main_en = 1; main_pair = 1; main_col = 4; step();

    // R7: upper source write ignored during update, lower write kept
    tag = "R7";
    upd_en = 1; upd_src_pair = 0; upd_dst_pair = 0; upd_col = 9;
    wr_we_e = 1; wr_we_o = 1; wr_lower = 0; wr_pair = 1; wr_col = 9;
    wr_pix_e = 8'hEE; wr_pix_o = 8'hDD; step();
    upd_en = 1; upd_src_pair = 1; upd_dst_pair = 0; upd_col = 8;
    wr_we_e = 1; wr_lower = 1; wr_pair = 0; wr_col = 8; wr_pix_e = 8'h77; step();
    blk_swap = 1; step();
    main_en = 1; main_pair = 1; main_col = 9; step();
    force_en = 1; force_pair = 0; force_col = 8; step();

    // R11: current force read dropped while update runs; previous read allowed
    tag = "R11";
    upd_en = 1; force_en = 1; force_prev = 0; force_pair = 1; force_col = 1; step();
    upd_en = 1; force_en = 1; force_prev = 1; force_pair = 1; force_col = 1; step();

    // R8: template ping-pong
    tag = "R8";
    tpl_we = 1; tpl_waddr = 3; tpl_wpix = 8'h9C; tpl_re = 1; tpl_raddr = 3; step();
    tpl_re = 1; tpl_raddr = 3; step();
    blk_swap = 1; step();
    tpl_re = 1; tpl_raddr = 3; step();

    // R9: outputs hold without requests
    tag = "R9";
    main_en = 1; main_pair = 0; main_col = 0; tpl_re = 1; tpl_raddr = 0; step();
    wr_we_e = 1; wr_pix_e = 8'hFF; step();
    step();

    // random mix
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      blk_swap   = ($urandom_range(39) == 0);
      wr_lower   = 1'($urandom);
      wr_we_e    = 1'($urandom);
      wr_we_o    = 1'($urandom);
      wr_pair    = wr_lower ? 2'($urandom_range(3)) : 2'($urandom_range(1));
      wr_col     = 4'($urandom_range(COLS - 1));
      wr_pix_e   = 8'($urandom);
      wr_pix_o   = 8'($urandom);
      upd_en     = ($urandom_range(5) == 0);
      upd_src_pair = 2'($urandom_range(3));
      upd_dst_pair = 2'($urandom_range(1));
      upd_col    = 4'($urandom_range(COLS - 1));
      main_en    = 1'($urandom);
      main_pair  = 2'($urandom_range(1));
      main_col   = 4'($urandom_range(COLS - 1));
      force_en   = 1'($urandom);
      force_prev = 1'($urandom);
      force_pair = 2'($urandom_range(3));
      force_col  = 4'($urandom_range(COLS - 1));
      tpl_we     = 1'($urandom);
      tpl_waddr  = 4'($urandom);
      tpl_wpix   = 8'($urandom);
      tpl_re     = 1'($urandom);
      tpl_raddr  = 4'($urandom);
      step();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule